// File: doc/BRIEF.md
# Orderly Halt Sequencer

This block decides the cycle in which a script-driven DMA controller may stop after an interrupt is raised. The controller keeps running whatever it has under way: an instruction fetch, a DMA data cycle, a bus request/acknowledge handshake, an outstanding synchronous offset, or a transfer-control instruction. Each of these must reach a safe point first, and only then does the sequencer report that the halt is complete.

When the interrupt comes from the bus side and the DMA direction is a write to memory, the sequencer first asks for the DMA FIFO to be flushed to memory, and it waits for the FIFO to empty. For any other source or direction, data may still be left in the FIFO at halt. A fetch in progress is allowed to finish, and the instruction pointer advances as usual. The fetched instruction is not started, so after the halt the pointer refers to the next instruction. A bus fault ends the fetch at once. After the halt the sequencer stays stopped until the interrupt request is withdrawn.

Top module: `halt_sequencer`

## Requirements
- R1: After reset, halt_done, flush_req, ip_advance and exec_go are all low.
- R2: If irq_req is sampled high while no activity is busy and no flush is needed, halt_done is high in the very next cycle.
- R3: halt_done is high for exactly one cycle per request. It is raised only after a cycle in which fetch_busy (unless bus_fault is high), data_busy, hs_busy, sync_pend and xfer_busy are all low. It does not rise again while irq_req stays high.
- R4: A fetch under way when the request arrives runs to completion. ip_advance pulses in the cycle where fetch_busy and fetch_done are high and bus_fault is low. exec_go pulses with ip_advance only when no halt request is present, and it is never raised during or after a halt.
- R5: With bus_fault high, a fetch in progress no longer holds off the halt, and ip_advance stays low.
- R6: When src_bus=1 (bus-side source) and dma_to_mem=1 and fifo_empty=0 at the moment the request is accepted, flush_req is high from the next cycle until fifo_empty rises. halt_done follows one cycle after the FIFO is seen empty.
- R7: For any other combination of source and direction, flush_req stays low and the halt does not wait for the FIFO, so fifo_empty may still be low when halt_done rises.
- R8: A bus handshake in progress (hs_busy), a pending synchronous offset (sync_pend), a DMA data cycle (data_busy) and an executing transfer-control instruction (xfer_busy) each hold off halt_done until they go low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 1 | Interrupt pending; held high until the halt has been taken |
| src_bus | input | 1 | 1: interrupt from the bus side, 0: DMA side |
| dma_to_mem | input | 1 | 1: DMA direction is write to memory |
| fetch_busy | input | 1 | Instruction fetch in progress |
| fetch_done | input | 1 | Last cycle of the current fetch |
| bus_fault | input | 1 | Bus fault on the current fetch |
| data_busy | input | 1 | DMA data cycle in progress |
| hs_busy | input | 1 | Bus request/acknowledge handshake in progress |
| sync_pend | input | 1 | Synchronous offset not yet drained |
| xfer_busy | input | 1 | Transfer-control instruction executing |
| fifo_empty | input | 1 | DMA FIFO holds no data |
| halt_done | output | 1 | One-cycle pulse: the halt has taken effect |
| flush_req | output | 1 | Request to flush the DMA FIFO to memory |
| ip_advance | output | 1 | Advance the instruction pointer |
| exec_go | output | 1 | Start executing the fetched instruction |

## Verification
The assertions assume that irq_req stays high from the moment it is raised until halt_done has been seen, and that each busy flag eventually falls. They also assume that fetch_done is only asserted together with fetch_busy, and that the FIFO empties once a flush is requested. The stimulus has stubs of the activity engines that meet these assumptions. Every busy flag is held for a randomly chosen number of cycles counted from the request. An aborted fetch is modelled as a single busy cycle with bus_fault. The FIFO model counts down only in cycles where flush_req is high. Between cases, irq_req and all activity flags are released for several cycles.

// File: rtl/halt_sequencer.sv
module halt_sequencer (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_req,
  input  logic src_bus,
  input  logic dma_to_mem,
  input  logic fetch_busy,
  input  logic fetch_done,
  input  logic bus_fault,
  input  logic data_busy,
  input  logic hs_busy,
  input  logic sync_pend,
  input  logic xfer_busy,
  input  logic fifo_empty,
  output logic halt_done,
  output logic flush_req,
  output logic ip_advance,
  output logic exec_go
);

  typedef enum logic [1:0] {S_RUN, S_WAIT, S_HALTED} state_t;

  state_t state;
  logic   need_flush;
  logic   acts_clear;
  logic   flush_now;

  assign acts_clear = ~data_busy & ~hs_busy & ~sync_pend & ~xfer_busy
                    & (~fetch_busy | bus_fault);
  assign flush_now  = src_bus & dma_to_mem & ~fifo_empty;

  assign flush_req  = (state == S_WAIT) & need_flush & ~fifo_empty;
  assign ip_advance = fetch_busy & fetch_done & ~bus_fault;
  assign exec_go    = ip_advance & (state == S_RUN) & ~irq_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_RUN;
      need_flush <= 1'b0;
      halt_done  <= 1'b0;
    end else begin
      halt_done <= 1'b0;
      unique case (state)
        S_RUN:
          if (irq_req) begin
            need_flush <= flush_now;
            if (acts_clear && !flush_now) begin
              state     <= S_HALTED;
              halt_done <= 1'b1;
            end else begin
              state <= S_WAIT;
            end
          end
        S_WAIT:
          if (acts_clear && (!need_flush || fifo_empty)) begin
            state      <= S_HALTED;
            halt_done  <= 1'b1;
            need_flush <= 1'b0;
          end
        S_HALTED:
          if (!irq_req) state <= S_RUN;
        default: state <= S_RUN;
      endcase
    end
  end

endmodule

module halt_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic irq_req,
  input logic fetch_busy,
  input logic bus_fault,
  input logic data_busy,
  input logic hs_busy,
  input logic sync_pend,
  input logic xfer_busy,
  input logic fifo_empty,
  input logic halt_done,
  input logic flush_req,
  input logic exec_go
);

  logic quiet;
  assign quiet = ~data_busy & ~hs_busy & ~sync_pend & ~xfer_busy & (~fetch_busy | bus_fault);

  AST_HALT_AFTER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    halt_done |-> $past(quiet)); // R3
  AST_HALT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    halt_done |=> !halt_done); // R3
  AST_IDLE_IRQ_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq_req) && quiet && fifo_empty && !halt_done) |=> halt_done); // R2
  AST_FLUSH_BEFORE_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    halt_done |-> !$past(flush_req)); // R6
  AST_NO_EXEC_AT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    halt_done |-> !exec_go); // R4

endmodule

bind halt_sequencer halt_seq_chk i_chk (.*);

// File: tb/test_halt_sequencer.sv
module test_halt_sequencer;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic irq_req = 0, src_bus = 0, dma_to_mem = 0, fetch_busy = 0, fetch_done = 0;
  logic bus_fault = 0, data_busy = 0, hs_busy = 0, sync_pend = 0, xfer_busy = 0;
  logic fifo_empty = 1;
  logic halt_done, flush_req, ip_advance, exec_go;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  halt_sequencer i_halt_sequencer (.*);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int exp_halt_cycle(input int df, input bit flt, input int dd, input int dh,
                                        input int ds, input int dx, input bit nf, input int f);
    int m;
    m = max2(max2(dd, dh), max2(ds, dx));
    m = max2(m, flt ? 0 : df);
    if (nf) m = max2(m, f + 1);
    return m + 1;
  endfunction

  task automatic release_all();
    @(negedge clk);
    irq_req = 0; fetch_busy = 0; fetch_done = 0; bus_fault = 0;
    data_busy = 0; hs_busy = 0; sync_pend = 0; xfer_busy = 0; fifo_empty = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_case(input string tag, input int df, input bit flt, input int dd,
                          input int dh, input int ds, input int dx, input int f,
                          input bit dir, input bit src);
    int fcnt, halt_at, halt_cnt, ip_cnt, exec_cnt, flush_cnt, fifo_at_halt, df_eff, exp_h;
    bit nf;
    fcnt = f; halt_at = -1; halt_cnt = 0; ip_cnt = 0; exec_cnt = 0; flush_cnt = 0;
    fifo_at_halt = -1;
    nf = src && dir && (f > 0);
    df_eff = (flt && df > 0) ? 1 : df;
    dma_to_mem = dir; src_bus = src;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      irq_req    = 1;
      fetch_busy = (c < df_eff);
      fetch_done = !flt && (df > 0) && (c == df - 1);
      bus_fault  = flt && (df > 0) && (c == 0);
      data_busy  = (c < dd);
      hs_busy    = (c < dh);
      sync_pend  = (c < ds);
      xfer_busy  = (c < dx);
      fifo_empty = (fcnt == 0);
      #1;
      if (halt_done) begin
        halt_cnt++;
        if (halt_at < 0) begin halt_at = c; fifo_at_halt = fifo_empty; end
      end
      if (ip_advance) ip_cnt++;
      if (exec_go) exec_cnt++;
      if (flush_req) begin flush_cnt++; if (fcnt > 0) fcnt--; end
    end
    exp_h = exp_halt_cycle(df, flt, dd, dh, ds, dx, nf, f);
    check({tag, " R3/R8 halt cycle"}, halt_at, exp_h);
    check({tag, " R3 single pulse"}, halt_cnt, 1);
    check({tag, " R4/R5 ip_advance count"}, ip_cnt, (df > 0 && !flt) ? 1 : 0);
    check({tag, " R4 no exec under irq"}, exec_cnt, 0);
    if (nf) check({tag, " R6 flush cycles"}, flush_cnt, f);
    else    check({tag, " R7 no flush"}, flush_cnt, 0);
    if (!nf && f > 0) check({tag, " R7 fifo still full at halt"}, fifo_at_halt, 0);
    release_all();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    #1;
    check("R1 halt_done reset", halt_done, 0);
    check("R1 flush_req reset", flush_req, 0);
    check("R1 ip_advance reset", ip_advance, 0);
    check("R1 exec_go reset", exec_go, 0);
    @(negedge clk); rst_n = 1;
    repeat (2) @(negedge clk);

    // R4: fetch without interrupt starts execution
    @(negedge clk); fetch_busy = 1; fetch_done = 0; #1;
    check("R4 no advance mid fetch", ip_advance, 0);
    @(negedge clk); fetch_done = 1; #1;
    check("R4 ip_advance on fetch end", ip_advance, 1);
    check("R4 exec_go without irq", exec_go, 1);
    release_all();

    // R2: idle request halts next cycle
    run_case("R2 idle", 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R5: bus fault aborts long fetch
    run_case("R5 fault", 5, 1, 0, 0, 0, 0, 0, 0, 0);
    // R4: fetch completes first
    run_case("R4 fetch", 4, 0, 0, 0, 0, 0, 0, 0, 0);
    // R6: flush on bus-side write to memory
    run_case("R6 flush", 0, 0, 0, 0, 0, 0, 3, 1, 1);
    // R7: DMA-side source, no flush
    run_case("R7 dmasrc", 0, 0, 2, 0, 0, 0, 3, 1, 0);
    // R7: read direction, no flush
    run_case("R7 read", 0, 0, 0, 0, 0, 0, 4, 0, 1);
    // R8: each activity alone
    run_case("R8 hs", 0, 0, 0, 5, 0, 0, 0, 0, 0);
    run_case("R8 sync", 0, 0, 0, 0, 6, 0, 0, 0, 0);
    run_case("R8 xfer", 0, 0, 0, 0, 0, 7, 0, 0, 0);
    run_case("R8 data", 0, 0, 3, 0, 0, 0, 0, 0, 0);

    for (int n = 0; n < 60; n++) begin
      run_case("rand", $urandom_range(0, 5), 1'($urandom_range(0, 1)), $urandom_range(0, 5),
               $urandom_range(0, 5), $urandom_range(0, 5), $urandom_range(0, 5),
               $urandom_range(0, 4), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule